// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers 32 interrupt sources and turns them into two request lines and one wake line. Every source carries a three-bit trigger code that chooses rising edge, falling edge, both edges, active-high level, active-low level or off. Edge events are held in two sticky status registers, one for rising and one for falling edges, until software clears them. Level sources are never held: they count as active only while the input sits at its active level. An active source reaches a request line only when its mask bit is 1. Its steering bit picks which of the two request lines it drives. A separate wake-enable register picks the sources that may drive the wake line.

Software reaches the block through a small register bus with one-cycle writes and combinational reads. Each control register has three aliases: a plain read, a write-1-to-set and a write-1-to-clear. A per-source source-select bit chooses between the synchronised external pin and a bit of an internal test register, so that software can inject interrupts.

Top module: `trig_intc`

## Requirements
- R1: After reset, the mask, wake, trigger-code, status, pending and test registers read 0. The steering and source-select registers read all ones. Both request lines and the wake line are low.
- R2: A write goes to address {index[3:0], op[1:0]}, where op 1 is the set alias and op 2 is the clear alias. A set write ORs the data into the register and a clear write removes the 1 bits of the data. Bits written as 0 keep their value. Writes to the set alias of a read-only register have no effect. Register indices: 0 code bit 0, 1 code bit 1, 2 code bit 2, 3 mask, 4 wake, 5 steering, 6 source select, 7 test, 8 rising status, 9 falling status, 10 pending for line 0, 11 pending for line 1.
- R3: Any register reads back in full at {index, op 0}, and the read data is combinational.
- R4: The trigger code {bit2,bit1,bit0} means: 001 rising, 010 falling, 011 both edges, 101 high level, 110 low level. Codes 000, 100 and 111 never make a source active.
- R5: A rising (falling) edge on a source whose code enables that edge sets its bit in the rising (falling) status register. The bit stays set until a 1 is written to it through the status clear alias. An edge that is latched in the same cycle as such a clear leaves the bit set.
- R6: A level source is active only while its input is at the active level, and it drops out of pending as soon as the input leaves that level.
- R7: A steering bit of 1 sends the source to request line 0, and a 0 sends it to line 1. No source appears in both pending registers.
- R8: A source with mask bit 0 appears in neither pending register.
- R9: Each request line is high exactly when its pending register, which reads as active, unmasked and steered sources, is nonzero.
- R10: The wake line is high when any active source has its wake bit set, whatever its mask bit.
- R11: With source-select bit 0, a source takes its value from the matching test-register bit, effective after the write edge, and its external pin is ignored.
- R12: An external pin change reaches a level source's request after the second rising clock edge, and an edge source's request after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Register index and alias |
| busWrEn | input | 1 | Write strobe, one cycle |
| busWrData | input | 32 | Write data, one bit per source |
| busRdData | output | 32 | Read data for busAddr |
| srcIn | input | 32 | Asynchronous interrupt pins |
| reqLine0 | output | 1 | Request line 0 |
| reqLine1 | output | 1 | Request line 1 |
| wakeOut | output | 1 | Wake line |

## Verification
Two things can hit the same status bit in one cycle: the latching of a hardware edge and a software clear of that bit. The bench raises a pin on a rising-edge source and times the clear write so that it lands on the third clock edge after the pin change, the edge on which the synchronised change gets latched. The read-back must then still show the bit set. A second clear with no edge in flight must then empty it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_N  = 12;
  localparam int IDX_W  = 4;
  localparam int CTL_N  = 8;

  localparam int R_CFG0   = 0;
  localparam int R_CFG1   = 1;
  localparam int R_CFG2   = 2;
  localparam int R_MASK   = 3;
  localparam int R_WAKE   = 4;
  localparam int R_STEER  = 5;
  localparam int R_SRCSEL = 6;
  localparam int R_TEST   = 7;
  localparam int R_RISE   = 8;
  localparam int R_FALL   = 9;
  localparam int R_PEND0  = 10;
  localparam int R_PEND1  = 11;

  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_SET  = 2'd1;
  localparam logic [1:0] OP_CLR  = 2'd2;

  typedef struct packed {
    logic [REG_N-1:0] setHit;
    logic [REG_N-1:0] clrHit;
    logic [IDX_W-1:0] rdIdx;
  } busStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [5:0]       busAddr,
  input  logic             busWrEn,
  output busStrobe_t       strb
);
  logic [IDX_W-1:0] idx;
  logic [1:0]       op;
  logic [REG_N-1:0] hitVec;

  assign idx = busAddr[5:2];
  assign op  = busAddr[1:0];

  always_comb begin
    hitVec = '0;
    for (int k = 0; k < REG_N; k++)
      if (idx == IDX_W'(k)) hitVec[k] = 1'b1;
  end

  always_comb begin
    strb.rdIdx  = idx;
    strb.setHit = (busWrEn && op == OP_SET) ? hitVec : '0;
    strb.clrHit = (busWrEn && op == OP_CLR) ? hitVec : '0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setHit, strb.clrHit})) else $error("AST_ONE_STROBE"); // R2
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2
)(
  input  logic            clk,
  input  logic            rstN,
  input  busStrobe_t      strb,
  input  logic [NSRC-1:0] wrData,
  input  logic [NSRC-1:0] srcIn,
  output logic [NSRC-1:0] rdData,
  output logic            reqLine0,
  output logic            reqLine1,
  output logic            wakeOut
);
  logic [NSRC-1:0] ctl [CTL_N];
  logic [NSRC-1:0] syncQ [SYNC_STAGES];
  logic [NSRC-1:0] selVal, prevVal, riseStat, fallStat;
  logic [NSRC-1:0] riseEn, fallEn, hiLvl, loLvl, active, pend0, pend1;

  function automatic logic [NSRC-1:0] ctlRstVal(int r);
    return (r == R_STEER || r == R_SRCSEL) ? '1 : '0;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < CTL_N; r++) ctl[r] <= ctlRstVal(r);
    end else begin
      for (int r = 0; r < CTL_N; r++)
        ctl[r] <= (ctl[r] | (strb.setHit[r] ? wrData : '0))
                  & ~(strb.clrHit[r] ? wrData : '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= srcIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign selVal = (syncQ[SYNC_STAGES-1] & ctl[R_SRCSEL]) | (ctl[R_TEST] & ~ctl[R_SRCSEL]);

  for (genvar i = 0; i < NSRC; i++) begin : g_trig
    logic [2:0] code;
    assign code      = {ctl[R_CFG2][i], ctl[R_CFG1][i], ctl[R_CFG0][i]};
    assign riseEn[i] = (code == 3'b001) || (code == 3'b011);
    assign fallEn[i] = (code == 3'b010) || (code == 3'b011);
    assign hiLvl[i]  = (code == 3'b101);
    assign loLvl[i]  = (code == 3'b110);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevVal  <= '0;
      riseStat <= '0;
      fallStat <= '0;
    end else begin
      prevVal  <= selVal;
      riseStat <= (riseStat & ~(strb.clrHit[R_RISE] ? wrData : '0))
                  | (selVal & ~prevVal & riseEn);
      fallStat <= (fallStat & ~(strb.clrHit[R_FALL] ? wrData : '0))
                  | (~selVal & prevVal & fallEn);
    end
  end

  assign active = (riseStat & riseEn) | (fallStat & fallEn)
                | (selVal & hiLvl) | (~selVal & loLvl);
  assign pend0  = active & ctl[R_MASK] & ctl[R_STEER];
  assign pend1  = active & ctl[R_MASK] & ~ctl[R_STEER];

  assign reqLine0 = |pend0;
  assign reqLine1 = |pend1;
  assign wakeOut  = |(active & ctl[R_WAKE]);

  always_comb begin
    rdData = '0;
    if (strb.rdIdx < IDX_W'(CTL_N)) rdData = ctl[strb.rdIdx[2:0]];
    else begin
      case (int'(strb.rdIdx))
        R_RISE:  rdData = riseStat;
        R_FALL:  rdData = fallStat;
        R_PEND0: rdData = pend0;
        R_PEND1: rdData = pend1;
        default: rdData = '0;
      endcase
    end
  end

  AST_STEER_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (pend0 & pend1) == '0) else $error("AST_STEER_EXCL"); // R7
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    ((pend0 | pend1) & ~ctl[R_MASK]) == '0) else $error("AST_MASK_GATE"); // R8
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrHit[R_RISE] |=> ((riseStat & $past(riseStat)) == $past(riseStat)))
    else $error("AST_EDGE_HOLD"); // R5
  AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrHit[R_FALL] |=> ((fallStat & $past(fallStat)) == $past(fallStat)))
    else $error("AST_FALL_HOLD"); // R5
endmodule

// File: rtl/trig_intc.sv
module trig_intc
  import intc_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic [5:0]      busAddr,
  input  logic            busWrEn,
  input  logic [NSRC-1:0] busWrData,
  output logic [NSRC-1:0] busRdData,
  input  logic [NSRC-1:0] srcIn,
  output logic            reqLine0,
  output logic            reqLine1,
  output logic            wakeOut
);
  busStrobe_t strb;

  intc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strb(strb)
  );

  intc_datapath #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData), .srcIn(srcIn),
    .rdData(busRdData), .reqLine0(reqLine0), .reqLine1(reqLine1), .wakeOut(wakeOut)
  );
endmodule

// File: tb/tb_trig_intc.sv
module tb_trig_intc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] srcIn = '0;
  logic        reqLine0, reqLine1, wakeOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] rd;

  // {code[2:0], steer, v0, v1, expReq0, expReq1}
  localparam logic [7:0] VEC [12] = '{
    8'b001_1_01_10, 8'b001_1_10_00, 8'b010_0_10_01, 8'b010_0_01_00,
    8'b011_1_10_10, 8'b011_0_01_01, 8'b101_1_01_10, 8'b101_1_10_00,
    8'b110_0_10_01, 8'b110_0_01_00, 8'b000_1_01_00, 8'b111_1_01_00
  };

  trig_intc dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .srcIn(srcIn),
    .reqLine0(reqLine0), .reqLine1(reqLine1), .wakeOut(wakeOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  function automatic logic [5:0] ad(int idx, int op);
    return {idx[3:0], op[1:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; holds the write across one rising edge
  task automatic wr(int idx, int op, logic [31:0] d);
    busAddr = ad(idx, op); busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rdReg(int idx, output logic [31:0] d);
    busAddr = ad(idx, 0); #1; d = busRdData;
  endtask

  initial begin
    tick(2); rstN = 1'b1; tick(1);

    // R1 reset state
    rdReg(3, rd); check("R1 mask", rd, 32'h0);
    rdReg(5, rd); check("R1 steer", rd, 32'hFFFF_FFFF);
    rdReg(6, rd); check("R1 srcsel", rd, 32'hFFFF_FFFF);
    rdReg(7, rd); check("R1 test", rd, 32'h0);
    check("R1 lines", {29'd0, reqLine0, reqLine1, wakeOut}, 32'h0);

    // R2 / R3 set-clear aliases and read-back
    wr(4, 1, 32'hF0); wr(4, 1, 32'h01); wr(4, 2, 32'h10);
    rdReg(4, rd); check("R2 set/clear keeps zero bits", rd, 32'hE1);
    wr(4, 2, 32'hFFFF_FFFF);
    rdReg(4, rd); check("R3 wake readback", rd, 32'h0);
    wr(10, 1, 32'hFFFF_FFFF);
    rdReg(10, rd); check("R2 read-only set ignored", rd, 32'h0);

    // R4 table walk on source 3
    wr(3, 1, 32'h8);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      v = VEC[i];
      for (int b = 0; b < 3; b++) begin
        wr(b, 2, 32'h8);
        if (v[5+b]) wr(b, 1, 32'h8);
      end
      wr(5, v[4] ? 1 : 2, 32'h8);
      srcIn[3] = v[3]; tick(4);
      wr(8, 2, 32'hFFFF_FFFF); wr(9, 2, 32'hFFFF_FFFF);
      srcIn[3] = v[2]; tick(4);
      check($sformatf("R4 vector %0d", i), {30'd0, reqLine0, reqLine1}, {30'd0, v[1], v[0]});
    end
    srcIn[3] = 1'b0; wr(3, 2, 32'h8); tick(3);

    // R12 latency: level source 7, edge source 9 (steer reset = line 0)
    wr(2, 1, 32'h80); wr(0, 1, 32'h280); wr(3, 1, 32'h280);
    srcIn[7] = 1'b1; tick(1);
    check("R12 level after 1 edge", {31'd0, reqLine0}, 32'h0);
    tick(1);
    check("R12 level after 2 edges", {31'd0, reqLine0}, 32'h1);
    rdReg(10, rd); check("R9 pending line 0", rd, 32'h80);
    srcIn[7] = 1'b0; tick(2);
    check("R6 level drops", {31'd0, reqLine0}, 32'h0);
    srcIn[9] = 1'b1; tick(2);
    check("R12 edge after 2 edges", {31'd0, reqLine0}, 32'h0);
    tick(1);
    check("R12 edge after 3 edges", {31'd0, reqLine0}, 32'h1);

    // R10 wake, R8 mask
    check("R10 wake off", {31'd0, wakeOut}, 32'h0);
    wr(4, 1, 32'h200);
    check("R10 wake on", {31'd0, wakeOut}, 32'h1);
    wr(3, 2, 32'h200);
    check("R8 masked drops request", {31'd0, reqLine0}, 32'h0);
    check("R10 wake ignores mask", {31'd0, wakeOut}, 32'h1);
    wr(4, 2, 32'h200); wr(3, 1, 32'h200);

    // R5 sticky status, falling not latched on rise-only source
    srcIn[9] = 1'b0; tick(4);
    rdReg(9, rd); check("R5 fall not latched", rd, 32'h0);
    rdReg(8, rd); check("R5 rise sticky", rd, 32'h200);
    wr(8, 2, 32'h200);
    rdReg(8, rd); check("R5 cleared", rd, 32'h0);
    // collision: clear lands on the latching edge
    srcIn[9] = 1'b1; tick(2);
    wr(8, 2, 32'h200);
    rdReg(8, rd); check("R5 edge beats clear", rd, 32'h200);
    wr(8, 2, 32'h200);
    rdReg(8, rd); check("R5 second clear", rd, 32'h0);
    srcIn[9] = 1'b0; wr(3, 2, 32'hFFFF_FFFF); tick(3);

    // R7 steering to line 1, R11 test path on source 12
    wr(2, 1, 32'h1000); wr(0, 1, 32'h1000); wr(3, 1, 32'h1000);
    wr(5, 2, 32'h1000); wr(6, 2, 32'h1000);
    srcIn[12] = 1'b1; tick(3);
    check("R11 pin ignored", {30'd0, reqLine0, reqLine1}, 32'h0);
    wr(7, 1, 32'h1000);
    check("R11 test bit drives R7 line 1", {30'd0, reqLine0, reqLine1}, 32'h1);
    rdReg(11, rd); check("R9 pending line 1", rd, 32'h1000);
    wr(7, 2, 32'h1000);
    check("R11 test bit cleared", {30'd0, reqLine0, reqLine1}, 32'h0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule